// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block is a small, fully associative translation cache. It maps virtual page numbers to physical frame numbers. Every slot holds a page-number tag, a frame number, an address-space identifier and four attribute flags: global, dirty, coherency and valid. It never holds page contents. A lookup gives the result in the same cycle, so a pipeline can qualify its memory access at once.

Each entry is tagged with an address-space identifier, so a context switch only has to change the identifier on the lookup port. A global flag lets shared kernel mappings match every address space. For systems that prefer a cold start, a single-cycle flush invalidates every entry that is not global.

On a miss the block only raises a miss flag. The page walk, the exception path and the retry belong to the surrounding logic, which writes the fetched entry through the fill port. Victim selection is set at run time: oldest-first, pseudo-random or least recently used.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, so any lookup misses, with `lk_pfn` and the attribute outputs at zero.
- R2: A lookup hits when a valid slot holds the requested page number and either its identifier equals `lk_asid` or its global flag is set. The hit, the frame number and the global, dirty and coherency flags of that slot appear in the same cycle. On a miss `lk_pfn` reads zero.
- R3: A non-global slot whose identifier differs from `lk_asid` is treated as absent. A lookup that would only match such a slot raises `lk_miss`.
- R4: A slot with the global flag set hits for any value of `lk_asid`.
- R5: With `lk_valid` low, both `lk_hit` and `lk_miss` stay low. In any cycle with neither a fill nor a flush, the set of valid slots does not change.
- R6: A fill is written on the next rising clock edge. During the fill cycle a lookup still sees the old contents. From the cycle after, a lookup with the filled page number and identifier hits.
- R7: A fill whose page number and identifier equal those of a valid slot rewrites that slot in place and allocates no second copy.
- R8: A pulse on `flush_local` clears, on the next edge, the valid flag of every slot whose global flag is clear. Global slots survive.
- R9: A new fill takes the lowest-numbered invalid slot. When all slots are valid, the policy on `repl_pol` picks the victim. With code 0 (oldest-first), and also with code 3, victims are taken in index order from slot 0 onward. The pointer advances once per such replacement.
- R10: With code 2 (least recently used), the victim is the slot touched longest ago. A touch is a fill into the slot, or a hit while `lk_valid` is high.
- R11: With code 1 (random), a free-running shift register picks the victim. Exactly one previously held mapping is lost and the new one is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| repl_pol | input | 2 | Victim policy: 0 oldest-first, 1 random, 2 least recently used, 3 as 0 |
| flush_local | input | 1 | Invalidate all non-global slots at the next edge |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_asid | input | ASID_W | Identifier of the active address space |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_miss | output | 1 | Lookup requested and not found |
| lk_pfn | output | PFN_W | Frame number of the hit slot, zero on a miss |
| lk_glb | output | 1 | Global flag of the hit slot |
| lk_dirty | output | 1 | Dirty flag of the hit slot |
| lk_coh | output | 1 | Coherency flag of the hit slot |
| fill_en | input | 1 | Write a mapping at the next edge |
| fill_vpn | input | VPN_W | Page number of the new mapping |
| fill_asid | input | ASID_W | Identifier of the new mapping |
| fill_pfn | input | PFN_W | Frame number of the new mapping |
| fill_glb | input | 1 | Global flag of the new mapping |
| fill_dirty | input | 1 | Dirty flag of the new mapping |
| fill_coh | input | 1 | Coherency flag of the new mapping |

## Verification
Lookups are tried with four kinds of input:
- A matching page number with the owning identifier, which separates a correct hit from a tag-only match.
- The same page number under a foreign identifier, which shows whether identifier qualification is applied.
- A global mapping under arbitrary identifiers, which exposes a missing override.
- An unknown page number, which confirms a clean miss.

Full-cache fill sequences are then replayed under each policy. The same preload followed by a hit on slot 0 evicts different slots under oldest-first and least recently used, so it tells the two policies apart. A repeated fill of one key, followed by a single extra fill, shows whether a duplicate was allocated.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        POL_FIFO = 2'd0,
        POL_RAND = 2'd1,
        POL_LRU  = 2'd2,
        POL_ALT  = 2'd3
    } repl_pol_e;

    localparam int unsigned LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    // Galois step of a maximal-length 16-bit shift register
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction

endpackage

// File: rtl/tlb_lookup.sv
// Parallel tag compare over all slots with a lowest-index priority pick.
module tlb_lookup #(
    parameter int unsigned N      = 8,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned ASID_W = 8,
    parameter bit          GLB_OVR = 1'b1,
    parameter int unsigned IDX_W  = $clog2(N)
) (
    input  logic [N-1:0]             vld_i,
    input  logic [N-1:0]             glb_i,
    input  logic [N-1:0][VPN_W-1:0]  vpn_tab_i,
    input  logic [N-1:0][ASID_W-1:0] asid_tab_i,
    input  logic [VPN_W-1:0]         vpn_i,
    input  logic [ASID_W-1:0]        asid_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         idx_o
);

    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic asid_ok;
        assign asid_ok  = (GLB_OVR && glb_i[i]) || (asid_tab_i[i] == asid_i);
        assign match[i] = vld_i[i] && (vpn_tab_i[i] == vpn_i) && asid_ok;
    end

    always_comb begin
        hit_o = |match;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
// Replacement state: oldest-first pointer, free-running LFSR, per-slot ages.
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                pol_i,
    input  logic                      touch_en_i,
    input  logic [IDX_W-1:0]          touch_idx_i,
    input  logic                      adv_i,
    output logic [IDX_W-1:0]          victim_o,
    output logic [N-1:0][IDX_W-1:0]   age_o
);

    typedef struct packed {
        logic [IDX_W-1:0]        ptr;
        logic [LFSR_W-1:0]       lfsr;
        logic [N-1:0][IDX_W-1:0] age;
    } vic_t;

    vic_t s_d, s_q;
    repl_pol_e pol;

    assign pol = repl_pol_e'(pol_i);

    always_comb begin
        s_d      = s_q;
        s_d.lfsr = lfsr_step(s_q.lfsr);
        if (adv_i) begin
            s_d.ptr = (s_q.ptr == IDX_W'(N - 1)) ? '0 : s_q.ptr + 1'b1;
        end
        if (touch_en_i) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx_i) begin
                    s_d.age[i] = '0;
                end else if (s_q.age[i] < s_q.age[touch_idx_i]) begin
                    s_d.age[i] = s_q.age[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim_o = s_q.ptr;
        unique case (pol)
            POL_RAND: victim_o = IDX_W'(s_q.lfsr % LFSR_W'(N));
            POL_LRU: begin
                victim_o = '0;
                for (int i = 0; i < N; i++) begin
                    if (s_q.age[i] == IDX_W'(N - 1)) victim_o = IDX_W'(i);
                end
            end
            default: victim_o = s_q.ptr;
        endcase
    end

    assign age_o = s_q.age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ptr  <= '0;
            s_q.lfsr <= LFSR_SEED;
            for (int i = 0; i < N; i++) s_q.age[i] <= IDX_W'(i);
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned N_ENT  = 8,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned PFN_W  = 20,
    parameter int unsigned ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        repl_pol,
    input  logic              flush_local,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_glb,
    output logic              lk_dirty,
    output logic              lk_coh,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_glb,
    input  logic              fill_dirty,
    input  logic              fill_coh
);

    localparam int unsigned IDX_W = $clog2(N_ENT);

    typedef struct packed {
        logic [N_ENT-1:0]             vld;
        logic [N_ENT-1:0]             glb;
        logic [N_ENT-1:0]             dty;
        logic [N_ENT-1:0]             coh;
        logic [N_ENT-1:0][VPN_W-1:0]  vpn;
        logic [N_ENT-1:0][ASID_W-1:0] asid;
        logic [N_ENT-1:0][PFN_W-1:0]  pfn;
    } tab_t;

    tab_t st_d, st_q;

    logic                          l_hit, d_hit, f_any;
    logic [IDX_W-1:0]              l_idx, d_idx, f_idx, v_idx, w_idx;
    logic                          alloc_adv, touch_en;
    logic [IDX_W-1:0]              touch_idx;
    logic [N_ENT-1:0][IDX_W-1:0]   ages;

    // Lookup path: identifier match with global override
    tlb_lookup #(
        .N(N_ENT), .VPN_W(VPN_W), .ASID_W(ASID_W), .GLB_OVR(1'b1), .IDX_W(IDX_W)
    ) u_look (
        .vld_i(st_q.vld), .glb_i(st_q.glb), .vpn_tab_i(st_q.vpn),
        .asid_tab_i(st_q.asid), .vpn_i(lk_vpn), .asid_i(lk_asid),
        .hit_o(l_hit), .idx_o(l_idx)
    );

    // Fill path: exact key match to rewrite in place
    tlb_lookup #(
        .N(N_ENT), .VPN_W(VPN_W), .ASID_W(ASID_W), .GLB_OVR(1'b0), .IDX_W(IDX_W)
    ) u_dup (
        .vld_i(st_q.vld), .glb_i(st_q.glb), .vpn_tab_i(st_q.vpn),
        .asid_tab_i(st_q.asid), .vpn_i(fill_vpn), .asid_i(fill_asid),
        .hit_o(d_hit), .idx_o(d_idx)
    );

    tlb_victim #(
        .N(N_ENT), .IDX_W(IDX_W)
    ) u_vic (
        .clk(clk), .rst_n(rst_n), .pol_i(repl_pol),
        .touch_en_i(touch_en), .touch_idx_i(touch_idx), .adv_i(alloc_adv),
        .victim_o(v_idx), .age_o(ages)
    );

    // Lowest-numbered free slot
    always_comb begin
        f_any = ~&st_q.vld;
        f_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) f_idx = IDX_W'(i);
        end
    end

    always_comb begin
        w_idx     = d_hit ? d_idx : (f_any ? f_idx : v_idx);
        alloc_adv = fill_en && !d_hit && !f_any;
        touch_en  = fill_en || (lk_valid && l_hit);
        touch_idx = fill_en ? w_idx : l_idx;
    end

    always_comb begin
        st_d = st_q;
        if (flush_local) st_d.vld = st_q.vld & st_q.glb;
        if (fill_en) begin
            st_d.vld[w_idx]  = 1'b1;
            st_d.glb[w_idx]  = fill_glb;
            st_d.dty[w_idx]  = fill_dirty;
            st_d.coh[w_idx]  = fill_coh;
            st_d.vpn[w_idx]  = fill_vpn;
            st_d.asid[w_idx] = fill_asid;
            st_d.pfn[w_idx]  = fill_pfn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        lk_hit   = lk_valid && l_hit;
        lk_miss  = lk_valid && !l_hit;
        lk_pfn   = l_hit ? st_q.pfn[l_idx] : '0;
        lk_glb   = l_hit && st_q.glb[l_idx];
        lk_dirty = l_hit && st_q.dty[l_idx];
        lk_coh   = l_hit && st_q.coh[l_idx];
    end

    // Flat views of the table for the bound checker
    logic [N_ENT-1:0]             ent_vld, ent_glb;
    logic [N_ENT-1:0][VPN_W-1:0]  ent_vpn;
    logic [N_ENT-1:0][ASID_W-1:0] ent_asid;
    assign ent_vld  = st_q.vld;
    assign ent_glb  = st_q.glb;
    assign ent_vpn  = st_q.vpn;
    assign ent_asid = st_q.asid;

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int unsigned N      = 8,
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned ASID_W = 8,
    parameter int unsigned IDX_W  = $clog2(N)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     lk_valid,
    input logic [VPN_W-1:0]         lk_vpn,
    input logic [ASID_W-1:0]        lk_asid,
    input logic                     lk_hit,
    input logic                     fill_en,
    input logic [VPN_W-1:0]         fill_vpn,
    input logic [ASID_W-1:0]        fill_asid,
    input logic                     flush_local,
    input logic [N-1:0]             ent_vld,
    input logic [N-1:0]             ent_glb,
    input logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input logic [N-1:0][ASID_W-1:0] ent_asid,
    input logic [IDX_W-1:0]         hit_idx,
    input logic [N-1:0][IDX_W-1:0]  ages
);

    logic [N-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) seen[ages[i]] = 1'b1;
    end

    // R6
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ((lk_valid && lk_vpn == $past(fill_vpn) && lk_asid == $past(fill_asid)) |-> lk_hit));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_local && !fill_en) |=> ((ent_vld & ~ent_glb) == '0));

    // R2
    hit_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (ent_vld[hit_idx] && ent_vpn[hit_idx] == lk_vpn &&
                    (ent_glb[hit_idx] || ent_asid[hit_idx] == lk_asid)));

    // R5
    hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !flush_local) |=> (ent_vld == $past(ent_vld)));

    // R10
    age_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &seen);

endmodule

bind asid_tlb tlb_chk #(
    .N(N_ENT), .VPN_W(VPN_W), .ASID_W(ASID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_asid(lk_asid), .lk_hit(lk_hit), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .flush_local(flush_local),
    .ent_vld(ent_vld), .ent_glb(ent_glb), .ent_vpn(ent_vpn),
    .ent_asid(ent_asid), .hit_idx(l_idx), .ages(ages)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  repl_pol = 2'd0;
    logic        flush_local = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_miss, lk_glb, lk_dirty, lk_coh;
    logic [19:0] lk_pfn;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_glb = 1'b0, fill_dirty = 1'b0, fill_coh = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    asid_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .repl_pol(repl_pol), .flush_local(flush_local),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
        .lk_glb(lk_glb), .lk_dirty(lk_dirty), .lk_coh(lk_coh),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_glb(fill_glb), .fill_dirty(fill_dirty),
        .fill_coh(fill_coh)
    );

    localparam logic [1:0] OP_FILL = 2'd0, OP_LOOK = 2'd1, OP_FLUSH = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic [19:0] pfn;
        logic        g;
        logic        hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{OP_FILL,  20'h00010, 8'd1, 20'hAAAA1, 1'b0, 1'b0, 4'd6},
        '{OP_FILL,  20'h00020, 8'd1, 20'hAAAA2, 1'b0, 1'b0, 4'd6},
        '{OP_FILL,  20'h00030, 8'd2, 20'hBBBB3, 1'b0, 1'b0, 4'd6},
        '{OP_FILL,  20'h00040, 8'd5, 20'hCCCC4, 1'b1, 1'b0, 4'd6},
        '{OP_LOOK,  20'h00010, 8'd1, 20'hAAAA1, 1'b0, 1'b1, 4'd2},  // R2 owner hit
        '{OP_LOOK,  20'h00010, 8'd2, 20'h00000, 1'b0, 1'b0, 4'd3},  // R3 foreign id
        '{OP_LOOK,  20'h00030, 8'd2, 20'hBBBB3, 1'b0, 1'b1, 4'd2},  // R2
        '{OP_LOOK,  20'h00030, 8'd1, 20'h00000, 1'b0, 1'b0, 4'd3},  // R3
        '{OP_LOOK,  20'h00040, 8'd9, 20'hCCCC4, 1'b0, 1'b1, 4'd4},  // R4 global
        '{OP_LOOK,  20'h00050, 8'd1, 20'h00000, 1'b0, 1'b0, 4'd2},  // R2 unknown
        '{OP_FLUSH, 20'h00000, 8'd0, 20'h00000, 1'b0, 1'b0, 4'd8},
        '{OP_LOOK,  20'h00010, 8'd1, 20'h00000, 1'b0, 1'b0, 4'd8},  // R8 cleared
        '{OP_LOOK,  20'h00040, 8'd3, 20'hCCCC4, 1'b0, 1'b1, 4'd8},  // R8 global kept
        '{OP_LOOK,  20'h00030, 8'd2, 20'h00000, 1'b0, 1'b0, 4'd8}   // R8
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fill_en = 1'b0; lk_valid = 1'b0; flush_local = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                           input logic g, input logic d, input logic c);
        @(negedge clk);
        lk_valid = 1'b0;
        fill_en = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p;
        fill_glb = g; fill_dirty = d; fill_coh = c;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        lk_valid = 1'b0; flush_local = 1'b1;
        @(negedge clk);
        flush_local = 1'b0;
    endtask

    task automatic do_look(input logic [19:0] v, input logic [7:0] a, input logic eh,
                           input logic [19:0] ep, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v; lk_asid = a;
        #1;
        chk(lk_hit == eh && lk_miss == !eh && lk_pfn == ep, req,
            {11'd0, lk_hit, lk_pfn}, {11'd0, eh, ep});
    endtask

    initial begin : watchdog
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int hits;
        do_reset();

        // R1: empty after reset
        do_look(20'h00010, 8'd1, 1'b0, 20'h0, "R1");
        chk(lk_glb == 1'b0 && lk_dirty == 1'b0 && lk_coh == 1'b0, "R1",
            {29'd0, lk_glb, lk_dirty, lk_coh}, 32'd0);

        // Vector table: fills, lookups across identifiers, flush
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_FILL:  do_fill(VEC[i].vpn, VEC[i].asid, VEC[i].pfn, VEC[i].g, 1'b0, 1'b0);
                OP_FLUSH: do_flush();
                default:  do_look(VEC[i].vpn, VEC[i].asid, VEC[i].hit, VEC[i].pfn,
                                  $sformatf("R%0d row %0d", VEC[i].req, i));
            endcase
        end

        // R2: attribute flags returned with the hit
        do_fill(20'h00099, 8'd4, 20'h12345, 1'b0, 1'b1, 1'b1);
        do_look(20'h00099, 8'd4, 1'b1, 20'h12345, "R2");
        chk(lk_dirty && lk_coh && !lk_glb, "R2 flags",
            {29'd0, lk_glb, lk_dirty, lk_coh}, 32'd3);

        // R5: no request, no flags
        @(negedge clk);
        lk_valid = 1'b0;
        #1;
        chk(!lk_hit && !lk_miss, "R5", {30'd0, lk_hit, lk_miss}, 32'd0);

        // R6: same-cycle lookup sees old contents, next cycle hits
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h00077; fill_asid = 8'd6; fill_pfn = 20'h0F0F0;
        fill_glb = 1'b0; fill_dirty = 1'b0; fill_coh = 1'b0;
        lk_valid = 1'b1; lk_vpn = 20'h00077; lk_asid = 8'd6;
        #1;
        chk(lk_miss && !lk_hit, "R6 same cycle", {31'd0, lk_hit}, 32'd0);
        @(negedge clk);
        fill_en = 1'b0;
        #1;
        chk(lk_hit && lk_pfn == 20'h0F0F0, "R6 next cycle", {12'd0, lk_pfn}, 32'h0F0F0);

        // R7 and R9: in-place rewrite, then oldest-first eviction
        do_reset();
        repl_pol = 2'd0;
        do_fill(20'h00100, 8'd3, 20'h11111, 1'b0, 1'b0, 1'b0);
        do_fill(20'h00100, 8'd3, 20'h22222, 1'b0, 1'b0, 1'b0);
        do_look(20'h00100, 8'd3, 1'b1, 20'h22222, "R7 rewrite");
        for (int i = 0; i < 7; i++) do_fill(20'h00200 + 20'(i), 8'd3, 20'h30000 + 20'(i), 1'b0, 1'b0, 1'b0);
        do_fill(20'h00300, 8'd3, 20'h40000, 1'b0, 1'b0, 1'b0);
        do_look(20'h00100, 8'd3, 1'b0, 20'h0, "R7 no duplicate");
        do_look(20'h00200, 8'd3, 1'b1, 20'h30000, "R9 slot1 kept");
        do_fill(20'h00301, 8'd3, 20'h40001, 1'b0, 1'b0, 1'b0);
        do_look(20'h00200, 8'd3, 1'b0, 20'h0, "R9 second victim");
        do_look(20'h00201, 8'd3, 1'b1, 20'h30001, "R9 slot2 kept");

        // R10: least recently used
        do_reset();
        repl_pol = 2'd2;
        for (int i = 0; i < 8; i++) do_fill(20'h00400 + 20'(i), 8'd7, 20'h50000 + 20'(i), 1'b0, 1'b0, 1'b0);
        do_look(20'h00400, 8'd7, 1'b1, 20'h50000, "R10 touch");
        do_fill(20'h00408, 8'd7, 20'h50008, 1'b0, 1'b0, 1'b0);
        do_look(20'h00401, 8'd7, 1'b0, 20'h0, "R10 victim");
        do_look(20'h00400, 8'd7, 1'b1, 20'h50000, "R10 touched kept");
        do_fill(20'h00409, 8'd7, 20'h50009, 1'b0, 1'b0, 1'b0);
        do_look(20'h00402, 8'd7, 1'b0, 20'h0, "R10 next victim");
        do_look(20'h00403, 8'd7, 1'b1, 20'h50003, "R10 kept");

        // R11: random victim, exactly one mapping lost
        do_reset();
        repl_pol = 2'd1;
        for (int i = 0; i < 8; i++) do_fill(20'h00500 + 20'(i), 8'd8, 20'h60000 + 20'(i), 1'b0, 1'b0, 1'b0);
        do_fill(20'h00508, 8'd8, 20'h60008, 1'b0, 1'b0, 1'b0);
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            lk_valid = 1'b1; lk_vpn = 20'h00500 + 20'(i); lk_asid = 8'd8;
            #1;
            if (lk_hit) hits++;
        end
        chk(hits == 7, "R11 one lost", 32'(hits), 32'd7);
        do_look(20'h00508, 8'd8, 1'b1, 20'h60008, "R11 new present");

        @(negedge clk);
        lk_valid = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule